// File: doc/BRIEF.md
# MDIO Management Master

This block gives a host a path to the registers of an Ethernet PHY over the two-wire management bus (MDC clock plus bidirectional MDIO data). The host sees two 16-bit registers, a command word and a data word. For a write, it loads the data word first. It then writes the command word with its start/busy bit set. The block builds a clause-22 management frame and shifts it out on MDIO. It clocks the frame with an MDC derived from the host clock by a divide ratio that the command selects.

For a read, the block releases MDIO for the turnaround and data phases and samples the PHY's reply on rising MDC edges. It then places the 16-bit result in the data word. The busy bit in the command word stays set for the whole frame. It falls when the last MDC cycle ends, so the host polls that bit to learn that the transaction has finished.

Top module: `mdio_master`

## Requirements
- R1: The command word layout is: PHY address in bits 15:11, register number in bits 10:6, bit 5 reads 0, clock-range code in bits 4:2, direction in bit 1 (1 = write, 0 = read), busy/start in bit 0. Reading the command word (select 0) returns the fields of the accepted command.
- R2: Writing the command word with bit 0 = 1 while idle starts a transaction. Busy reads 1 from the next cycle until the frame ends, then reads 0.
- R3: A command write with bit 0 = 0 starts nothing. Busy stays 0 and MDC stays low.
- R4: The MDC period in host cycles is 42, 62, 16, 26, 102 or 124 for codes 0 to 5. Codes 6 and 7 give 124. MDC is high for half of each period.
- R5: A write frame carries the value that the data word (select 1) held when the command was accepted.
- R6: After a read completes, the data word holds the 16 bits sampled from MDIO, first sampled bit as MSB.
- R7: Each frame has 64 MDC rising edges carrying, in order: 32 ones, start 01, opcode 10 (read) or 01 (write), PHY address and register number MSB first, turnaround, and 16 data bits MSB first. A write drives turnaround as 10.
- R8: During a read, the MDIO output enable is low for the 18 bit times of turnaround and data, and high for the first 46. A write drives all 64. The enable is low when idle.
- R9: Driven MDIO data changes only while MDC is low. Each bit is therefore stable at the rising MDC edge.
- R10: A command write that arrives while busy is 1 is ignored. The readback fields and the frame in flight are unchanged.
- R11: MDC is low whenever no transaction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 command word, 1 data word |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Frame completion and a new command write can land in the same host cycle. Busy is still 1 in that cycle, so the write must be dropped, and the next cycle's write must start the next transaction. The bench provokes this by writing a second command on every cycle while a first read is in flight. It then judges that the readback kept the first command's fields, that the first frame came out intact, and that the second frame and its read result match the second command exactly.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int SEL_W  = 3;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 7;

  typedef struct packed {
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regad;
    logic [SEL_W-1:0] div_sel;
    logic             wr;
  } cmd_t;

  // host-clock cycles per MDC period
  function automatic logic [DIV_W-1:0] div_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    div_ratio = DIV_W'(42);
      3'd1:    div_ratio = DIV_W'(62);
      3'd2:    div_ratio = DIV_W'(16);
      3'd3:    div_ratio = DIV_W'(26);
      3'd4:    div_ratio = DIV_W'(102);
      default: div_ratio = DIV_W'(124);
    endcase
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              start_o,
  output logic              busy_o,
  output cmd_t              cmd_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] rdata_o
);
  cmd_t              cmd_q;
  logic              busy_q;
  logic [DATA_W-1:0] data_q;
  logic              unused_bits;

  assign unused_bits = wdata_i[5];
  // start only from idle; writes while busy are dropped
  assign start_o = we_i & ~sel_i & wdata_i[0] & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_o) begin
      cmd_q.phy     <= wdata_i[15:11];
      cmd_q.regad   <= wdata_i[10:6];
      cmd_q.div_sel <= wdata_i[4:2];
      cmd_q.wr      <= wdata_i[1];
      busy_q        <= 1'b1;
    end else if (done_i) begin
      busy_q <= 1'b0;
    end
  end

  // read completion takes priority over a host data write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  data_q <= '0;
    else if (done_i && !cmd_q.wr) data_q <= rd_data_i;
    else if (we_i && sel_i)       data_q <= wdata_i;
  end

  assign busy_o  = busy_q;
  assign cmd_o   = cmd_q;
  assign data_o  = data_q;
  assign rdata_o = sel_i ? data_q
                         : {cmd_q.phy, cmd_q.regad, 1'b0, cmd_q.div_sel, cmd_q.wr, busy_q};
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half;

  assign half   = ratio_i >> 1;
  assign rise_o = en_i & (cnt_q == half - DIV_W'(1));
  assign fall_o = en_i & (cnt_q == ratio_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + DIV_W'(1);
      if (rise_o)      mdc_o <= 1'b1;
      else if (fall_o) mdc_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [REG_W-1:0]  regad_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int HDR_LEN   = 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int FRAME_LEN = PRE_LEN + HDR_LEN;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);
  localparam logic [IDX_W-1:0] PRE_I  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] TA_I   = IDX_W'(PRE_LEN + 4 + PHY_W + REG_W);
  localparam logic [IDX_W-1:0] DATA_I = IDX_W'(FRAME_LEN - DATA_W);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(FRAME_LEN - 1);

  logic               active_q, wr_q;
  logic [IDX_W-1:0]   idx_q, nidx;
  logic [HDR_LEN-1:0] hdr_q;
  logic [DATA_W-1:0]  rdata_q;

  assign nidx   = idx_q + IDX_W'(1);
  assign done_o = active_q & fall_i & (idx_q == LAST_I);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      wr_q      <= 1'b0;
      idx_q     <= '0;
      hdr_q     <= '0;
      rdata_q   <= '0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b0;
    end else if (start_i) begin
      active_q  <= 1'b1;
      wr_q      <= wr_i;
      idx_q     <= '0;
      hdr_q     <= {2'b01, wr_i ? 2'b01 : 2'b10, phy_i, regad_i,
                    wr_i ? 2'b10 : 2'b00, wr_i ? wdata_i : '0};
      rdata_q   <= '0;
      mdio_o    <= 1'b1;
      mdio_oe_o <= 1'b1;
    end else if (active_q) begin
      if (rise_i && !wr_q && idx_q >= DATA_I)
        rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
      if (done_o) begin
        active_q  <= 1'b0;
        mdio_o    <= 1'b1;
        mdio_oe_o <= 1'b0;
      end else if (fall_i) begin
        idx_q     <= nidx;
        // data only moves on the falling MDC edge
        mdio_o    <= (nidx < PRE_I) ? 1'b1 : (hdr_q[HDR_LEN-1] | (!wr_q && nidx >= TA_I));
        mdio_oe_o <= wr_q | (nidx < TA_I);
        if (nidx >= PRE_I) hdr_q <= {hdr_q[HDR_LEN-2:0], 1'b0};
      end
    end
  end

  assign active_o = active_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  cmd_t              cmd_q;
  logic              start, busy, seq_done, seq_active, rise, fall;
  logic [DATA_W-1:0] data_q, seq_rdata;

  mdio_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .done_i    (seq_done),
    .rd_data_i (seq_rdata),
    .start_o   (start),
    .busy_o    (busy),
    .cmd_o     (cmd_q),
    .data_o    (data_q),
    .rdata_o   (reg_rdata_o)
  );

  mdio_clkgen u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (seq_active),
    .ratio_i (div_ratio(cmd_q.div_sel)),
    .mdc_o   (mdc_o),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  // frame fields come straight from the write data so the start cycle sees them
  mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .wr_i      (reg_wdata_i[1]),
    .phy_i     (reg_wdata_i[15:11]),
    .regad_i   (reg_wdata_i[10:6]),
    .wdata_i   (data_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (seq_active),
    .done_o    (seq_done),
    .rdata_o   (seq_rdata),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic done_i,
  input logic mdc_i,
  input logic mdio_i,
  input logic oe_i,
  input logic we_i,
  input logic sel_i,
  input logic wbit0_i,
  input cmd_t cmd_i
);
  a_r2_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |=> busy_i);
  a_r2_busy_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !busy_i);
  a_r3_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && we_i && !sel_i && !wbit0_i |=> !busy_i);
  a_r10_cmd_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |=> $stable(cmd_i));
  a_r11_mdc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i);
  a_r8_oe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !oe_i);
  a_r9_change_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_i) |-> !mdc_i);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy),
  .done_i  (seq_done),
  .mdc_i   (mdc_o),
  .mdio_i  (mdio_o),
  .oe_i    (mdio_oe_o),
  .we_i    (reg_we_i),
  .sel_i   (reg_sel_i),
  .wbit0_i (reg_wdata_i[0]),
  .cmd_i   (cmd_q)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i = 1'b1;

  int checks = 0, errors = 0;
  int cyc = 0, rise_cnt = 0, t0 = 0, per = 0;
  logic        mdc_prev = 1'b0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: capture on MDC rise, answer on MDC fall
  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdc_prev) begin
      if (rise_cnt < 64) begin
        cap_o[63-rise_cnt]  = mdio_o;
        cap_oe[63-rise_cnt] = mdio_oe;
      end
      if (rise_cnt == 0) t0 = cyc;
      if (rise_cnt == 1) per = cyc - t0;
      rise_cnt++;
    end
    if (!mdc && mdc_prev)
      mdio_i = (rise_cnt >= 48 && rise_cnt <= 63) ? phy_val[63-rise_cnt] : 1'b1;
    mdc_prev = mdc;
  end

  function automatic int exp_ratio(input logic [2:0] c);
    case (c)
      3'd0: return 42;
      3'd1: return 62;
      3'd2: return 16;
      3'd3: return 26;
      3'd4: return 102;
      default: return 124;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic w, input logic [4:0] p,
      input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, p, r, w ? 2'b10 : 2'b00, w ? d : 16'h0};
  endfunction

  function automatic logic [15:0] cmd_word(input logic w, input logic [4:0] p,
      input logic [4:0] r, input logic [2:0] c, input logic b);
    return {p, r, 1'b0, c, w, b};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
      input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic s, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic host_rd(input logic s, output logic [15:0] d);
    @(negedge clk);
    sel = s;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    int n = 0;
    do begin
      host_rd(1'b0, v);
      n++;
    end while (v[0] && n < 20000);
  endtask

  task automatic verify_frame(input logic w, input logic [4:0] p, input logic [4:0] r,
      input logic [2:0] c, input logic [15:0] d, input logic [15:0] pv, input string tag);
    logic [63:0] ef, eoe;
    logic [15:0] v;
    ef  = exp_frame(w, p, r, d);
    eoe = w ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
    check(rise_cnt == 64, {"R7 edge count ", tag}, 64'(rise_cnt), 64);
    check((cap_o & eoe) == (ef & eoe), {"R7/R5 frame ", tag}, cap_o & eoe, ef & eoe);
    check(cap_oe == eoe, {"R8 enable ", tag}, cap_oe, eoe);
    check(per == exp_ratio(c), {"R4 period ", tag}, 64'(per), 64'(exp_ratio(c)));
    check(!mdc && !mdio_oe, {"R11 idle ", tag}, {mdc, mdio_oe}, 0);
    if (!w) begin
      host_rd(1'b1, v);
      check(v == pv, {"R6 read data ", tag}, v, pv);
    end
  endtask

  task automatic run_txn(input logic w, input logic [4:0] p, input logic [4:0] r,
      input logic [2:0] c, input logic [15:0] d, input logic [15:0] pv, input string tag);
    logic [15:0] v;
    phy_val = pv; rise_cnt = 0; per = 0;
    if (w) host_wr(1'b1, d);
    host_wr(1'b0, cmd_word(w, p, r, c, 1'b1));
    host_rd(1'b0, v);
    check(v[0] == 1'b1, {"R2 busy set ", tag}, v, 1);
    check(v[15:1] == cmd_word(w, p, r, c, 1'b1) >> 1, {"R1 readback ", tag},
          v, cmd_word(w, p, r, c, 1'b1));
    wait_idle();
    host_rd(1'b0, v);
    check(v[0] == 1'b0, {"R2 busy clear ", tag}, v, 0);
    verify_frame(w, p, r, c, d, pv, tag);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    host_rd(1'b0, v);
    check(v == 16'h0, "R1 reset command word", v, 0);
    host_rd(1'b1, v);
    check(v == 16'h0, "R6 reset data word", v, 0);
    check(!mdc && !mdio_oe, "R11 reset idle", {mdc, mdio_oe}, 0);

    // R3: command without start bit
    rise_cnt = 0;
    host_wr(1'b0, 16'h0000);
    host_wr(1'b0, cmd_word(1'b0, 5'd4, 5'd2, 3'd2, 1'b0));
    repeat (60) @(negedge clk);
    host_rd(1'b0, v);
    check(v[0] == 1'b0, "R3 busy stays 0", v, 0);
    check(rise_cnt == 0, "R3 no MDC activity", 64'(rise_cnt), 0);

    // directed corners
    run_txn(1'b1, 5'd31, 5'd31, 3'd2, 16'hFFFF, 16'h0, "write all ones");
    run_txn(1'b1, 5'd0, 5'd0, 3'd2, 16'h0000, 16'h0, "write all zeros");
    run_txn(1'b0, 5'd1, 5'd30, 3'd2, 16'h0, 16'h8001, "read edge bits");

    // R4 divider sweep, all codes
    for (int c = 0; c < 8; c++)
      run_txn(1'b0, 5'(c), 5'(c + 3), 3'(c), 16'h0, 16'(16'hA5C3 ^ c), "sweep");

    // random mix
    for (int i = 0; i < 10; i++) begin
      logic w;
      logic [2:0] c;
      w = 1'($urandom % 2);
      c = ($urandom % 2) ? 3'd2 : 3'd3;
      run_txn(w, 5'($urandom), 5'($urandom), c, 16'($urandom), 16'($urandom), "random");
    end

    // R10: hammer command writes across the completion cycle
    begin
      logic [15:0] a_cmd, b_cmd;
      int n = 0;
      a_cmd = cmd_word(1'b0, 5'd3, 5'd7, 3'd2, 1'b1);
      b_cmd = cmd_word(1'b0, 5'd9, 5'd21, 3'd2, 1'b1);
      phy_val = 16'h1234; rise_cnt = 0; per = 0;
      host_wr(1'b0, a_cmd);
      @(negedge clk);
      we = 1'b1; sel = 1'b0; wdata = b_cmd;
      do begin
        @(negedge clk);
        #1 v = rdata;
        n++;
        if (n == 5)
          check(v == a_cmd, "R10 ignored while busy", v, a_cmd);
      end while (v[15:11] != 5'd9 && n < 20000);
      we = 1'b0;
      check(v == b_cmd, "R10 next command after completion", v, b_cmd);
      check(rise_cnt == 64, "R10 first frame length", 64'(rise_cnt), 64);
      check((cap_o >> 18) == (exp_frame(1'b0, 5'd3, 5'd7, 16'h0) >> 18),
            "R10 first frame intact", cap_o, exp_frame(1'b0, 5'd3, 5'd7, 16'h0));
      host_rd(1'b1, v);
      check(v == 16'h1234, "R6 first read result", v, 16'h1234);
      rise_cnt = 0; per = 0; phy_val = 16'hC0DE;
      wait_idle();
      verify_frame(1'b0, 5'd9, 5'd21, 3'd2, 16'h0, 16'hC0DE, "after hammer");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule